// File: doc/BRIEF.md
# Floating-Point Normalize and Round Unit

This block takes the raw result of a floating-point operation and turns it into a finished 32-bit word. The raw value is a sign, a signed true exponent and a 28-bit unnormalized mantissa. The mantissa has one integer (overflow) bit above the binary point, 24 retained fraction bits and 3 guard bits. The block moves the leading one to the first fraction position and adjusts the exponent to match. It then reduces the guard bits with a selectable method and renormalizes if that step carries out of the fraction.

The packed result has the sign in bit 31, the exponent in bits 30:24 in excess-64 coding (the true exponent plus 64), and the fraction in bits 23:0 in the form 0.1xxx. Three flags come with the word: exponent overflow, exponent underflow and exact zero. Each accepted input produces one registered result one clock later.

Top module: `fpnr_unit`

## Requirements
- R1: A cycle with `in_valid_i` high gives `out_valid_o` high on the next cycle, with the result updated at that same edge. With `in_valid_i` low, `out_valid_o` drops on the next edge and `word_o` and the flags hold their values. After reset all outputs are 0.
- R2: For a nonzero, in-range result, `word_o[23]` is 1, bits 22:0 hold the remaining fraction bits, bits 30:24 hold the true exponent plus 64, and bit 31 is `sign_i`.
- R3: In `mant_i`, bit 27 is the integer bit and the bits below it are fraction bits. When bit 27 is 0 and the leading one is at bit p, the mantissa is shifted left by 26−p and the exponent is lowered by 26−p. After the shift, bits 26:3 are the retained fraction and bits 2:0 are the guard bits.
- R4: When bit 27 of `mant_i` is 1, the mantissa is shifted right one place and the exponent is raised by 1. The bit shifted out is ORed into the lowest guard bit.
- R5: Mode 00 (chop) drops the guard bits without changing the retained fraction.
- R6: Mode 01 (jam) drops the guard bits and forces the retained LSB to 1 if any guard bit was 1.
- R7: Mode 10 (round) adds 1 at the retained LSB when the top guard bit is 1, and otherwise leaves the retained fraction as it is.
- R8: Mode 11 behaves exactly like mode 00.
- R9: If rounding carries out of the 24-bit fraction, the fraction becomes 0x800000 and the exponent rises by one more.
- R10: An all-zero `mant_i` gives `word_o` = 0 (sign cleared too) with `zero_o` = 1, and with `ovf_o` and `unf_o` both 0.
- R11: A final true exponent above 63 sets `ovf_o`, and `word_o` becomes {sign, 7'h7F, 24'hFFFFFF}. At most one of the three flags is set at a time.
- R12: A final true exponent below −64 sets `unf_o`, and `word_o` becomes {sign, 31'h0}. The exponents −64 and 63 are in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Raw value present this cycle |
| sign_i | input | 1 | Sign of the raw value |
| exp_i | input | 10 | Signed true exponent of the raw value |
| mant_i | input | 28 | Raw mantissa: integer bit, 24 fraction bits, 3 guard bits |
| mode_i | input | 2 | Guard reduction: 00 chop, 01 jam, 10 round, 11 chop |
| out_valid_o | output | 1 | Result registered this cycle |
| word_o | output | 32 | Packed sign, excess-64 exponent, fraction |
| ovf_o | output | 1 | Exponent overflow |
| unf_o | output | 1 | Exponent underflow |
| zero_o | output | 1 | Exact zero result |

## Verification
The whole datapath is combinational between the input ports and a single output register, so every result and flag is due exactly one rising edge after the cycle in which `in_valid_i` is high. The bench drives each input on a falling edge and holds it for one full period. It samples all outputs on the next falling edge, half a period after the register has loaded. It then samples once more, one cycle later with `in_valid_i` low, to confirm that `out_valid_o` has dropped and the word has held.

// File: rtl/fpnr_pkg.sv
package fpnr_pkg;
  typedef enum logic [1:0] {
    RND_CHOP    = 2'b00,
    RND_JAM     = 2'b01,
    RND_HALF_UP = 2'b10,
    RND_RSVD    = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/fpnr_lod.sv
module fpnr_lod #(
  parameter int W  = 28,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o,
  output logic          found_o
);
  // highest set bit wins: later iterations override earlier ones
  always_comb begin
    pos_o   = '0;
    found_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        pos_o   = PW'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpnr_norm_shift.sv
module fpnr_norm_shift #(
  parameter int W  = 28,
  parameter int PW = 5,
  parameter int XW = 12
) (
  input  logic [W-1:0]         mant_i,
  input  logic [PW-1:0]        pos_i,
  output logic [W-1:0]         norm_o,
  output logic signed [XW-1:0] exp_adj_o
);
  localparam int TGT = W - 2;

  logic [PW-1:0] lsh;

  always_comb begin
    lsh = PW'(TGT) - pos_i;
    if (pos_i == PW'(W - 1)) begin
      // integer bit set: one right shift, sticky the lost bit
      norm_o    = {1'b0, mant_i[W-1:2], mant_i[1] | mant_i[0]};
      exp_adj_o = XW'(1);
    end else begin
      norm_o    = mant_i << lsh;
      exp_adj_o = -$signed({{(XW-PW){1'b0}}, lsh});
    end
  end
endmodule

// File: rtl/fpnr_round.sv
module fpnr_round
  import fpnr_pkg::*;
#(
  parameter int FW = 24,
  parameter int GW = 3
) (
  input  logic [FW+GW-1:0] body_i,
  input  rnd_mode_e        mode_i,
  output logic [FW-1:0]    frac_o,
  output logic             carry_o
);
  logic [FW-1:0] ret;
  logic [GW-1:0] grd;
  logic [FW:0]   sum;

  assign ret = body_i[FW+GW-1:GW];
  assign grd = body_i[GW-1:0];
  assign sum = {1'b0, ret} + {{FW{1'b0}}, grd[GW-1]};

  always_comb begin
    frac_o  = ret;
    carry_o = 1'b0;
    unique case (mode_i)
      RND_JAM:     frac_o = ret | {{(FW-1){1'b0}}, |grd};
      RND_HALF_UP: begin
        carry_o = sum[FW];
        // carry out means 1.000.., renormalized to 0.1000..
        frac_o  = sum[FW] ? {1'b1, {(FW-1){1'b0}}} : sum[FW-1:0];
      end
      default:     frac_o = ret;
    endcase
  end
endmodule

// File: rtl/fpnr_unit.sv
module fpnr_unit
  import fpnr_pkg::*;
#(
  parameter int EXP_W     = 7,
  parameter int FRAC_W    = 24,
  parameter int GUARD_W   = 3,
  parameter int RAW_EXP_W = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  input  logic                        sign_i,
  input  logic signed [RAW_EXP_W-1:0] exp_i,
  input  logic [FRAC_W+GUARD_W:0]     mant_i,
  input  logic [1:0]                  mode_i,
  output logic                        out_valid_o,
  output logic [EXP_W+FRAC_W:0]       word_o,
  output logic                        ovf_o,
  output logic                        unf_o,
  output logic                        zero_o
);
  localparam int MANT_W = FRAC_W + GUARD_W + 1;
  localparam int POS_W  = $clog2(MANT_W);
  localparam int XW     = RAW_EXP_W + 2;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int BIAS   = 1 << (EXP_W - 1);
  localparam int EMAX   = BIAS - 1;
  localparam int EMIN   = -BIAS;

  logic [POS_W-1:0]       lod_pos;
  logic                   lod_found;
  logic [MANT_W-1:0]      norm;
  logic signed [XW-1:0]   exp_adj;
  logic [FRAC_W-1:0]      rnd_frac;
  logic                   rnd_carry;
  logic signed [XW-1:0]   exp_ext, exp_norm, exp_fin;
  logic                   ovf_c, unf_c;
  logic [WORD_W-1:0]      word_c;

  fpnr_lod #(.W(MANT_W), .PW(POS_W)) u_lod (
    .vec_i   (mant_i),
    .pos_o   (lod_pos),
    .found_o (lod_found)
  );

  fpnr_norm_shift #(.W(MANT_W), .PW(POS_W), .XW(XW)) u_shift (
    .mant_i    (mant_i),
    .pos_i     (lod_pos),
    .norm_o    (norm),
    .exp_adj_o (exp_adj)
  );

  fpnr_round #(.FW(FRAC_W), .GW(GUARD_W)) u_round (
    .body_i  (norm[MANT_W-2:0]),
    .mode_i  (rnd_mode_e'(mode_i)),
    .frac_o  (rnd_frac),
    .carry_o (rnd_carry)
  );

  assign exp_ext  = {{(XW-RAW_EXP_W){exp_i[RAW_EXP_W-1]}}, exp_i};
  assign exp_norm = exp_ext + exp_adj;
  assign exp_fin  = exp_norm + $signed({{(XW-1){1'b0}}, rnd_carry});
  assign ovf_c    = lod_found && (exp_fin > $signed(XW'(EMAX)));
  assign unf_c    = lod_found && (exp_fin < $signed(XW'(EMIN)));

  always_comb begin
    if (!lod_found)  word_c = '0;
    else if (ovf_c)  word_c = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
    else if (unf_c)  word_c = {sign_i, {(WORD_W-1){1'b0}}};
    else             word_c = {sign_i, EXP_W'(exp_fin + XW'(BIAS)), rnd_frac};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      word_o      <= '0;
      ovf_o       <= 1'b0;
      unf_o       <= 1'b0;
      zero_o      <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        word_o <= word_c;
        ovf_o  <= ovf_c;
        unf_o  <= unf_c;
        zero_o <= !lod_found;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R1
  AST_HOLD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(word_o)); // R1
  AST_NORM_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && lod_found |-> norm[MANT_W-2] && !norm[MANT_W-1]); // R3
  AST_NORM_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !zero_o && !unf_o |-> word_o[FRAC_W-1]); // R2
  AST_NO_CARRY_CHOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && mode_i != RND_HALF_UP |-> !rnd_carry); // R9
  AST_ZERO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && zero_o |-> word_o == '0); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_o, unf_o, zero_o})); // R11
  AST_OVF_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && ovf_o |-> word_o[WORD_W-2:0] == '1); // R11
  AST_UNF_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && unf_o |-> word_o[WORD_W-2:0] == '0); // R12
endmodule

// File: tb/fpnr_unit_test.sv
module fpnr_unit_test;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              sign_in = 1'b0;
  logic signed [9:0] exp_in = '0;
  logic [27:0]       mant_in = '0;
  logic [1:0]        mode_in = 2'b00;
  logic              out_valid;
  logic [31:0]       word;
  logic              ovf, unf, zero;
  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  fpnr_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .sign_i(sign_in),
    .exp_i(exp_in), .mant_i(mant_in), .mode_i(mode_in),
    .out_valid_o(out_valid), .word_o(word), .ovf_o(ovf), .unf_o(unf), .zero_o(zero)
  );

  // {word, ovf, unf, zero} from the requirements
  function automatic logic [34:0] model(input logic s, input int e, input logic [27:0] m,
                                        input logic [1:0] md);
    logic [27:0] v;
    logic [24:0] r;
    logic [2:0]  g;
    int x;
    if (m == 0) return {32'h0, 3'b001};
    v = m;
    x = e;
    if (v[27]) begin
      v = (m >> 1) | {27'b0, m[0]};
      x = x + 1;
    end
    while (!v[26]) begin
      v = v << 1;
      x = x - 1;
    end
    r = {1'b0, v[26:3]};
    g = v[2:0];
    if (md == 2'b01 && g != 0) r[0] = 1'b1;
    if (md == 2'b10 && g[2]) r = r + 1;
    if (r[24]) begin
      r = 25'h0800000;
      x = x + 1;
    end
    if (x > 63) return {s, 7'h7F, 24'hFFFFFF, 3'b100};
    if (x < -64) return {s, 31'h0, 3'b010};
    return {s, 7'(x + 64), r[23:0], 3'b000};
  endfunction

  task automatic check(input string req, input logic [34:0] got, input logic [34:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one input, sample the registered result one cycle later
  task automatic run(input logic s, input int e, input logic [27:0] m, input logic [1:0] md,
                     output logic [34:0] res);
    @(negedge clk);
    in_valid = 1'b1; sign_in = s; exp_in = 10'(e); mant_in = m; mode_in = md;
    @(negedge clk);
    in_valid = 1'b0;
    res = {word, ovf, unf, zero};
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R1: out_valid got %b expected 1", out_valid);
    end
  endtask

  task automatic expect_word(input string req, input logic s, input int e, input logic [27:0] m,
                             input logic [1:0] md, input logic [34:0] exp);
    logic [34:0] res;
    run(s, e, m, md, res);
    check(req, res, exp);
  endtask

  task automatic t_reset();
    check("R1 reset", {word, ovf, unf, zero}, 35'h0);
    check("R1 reset valid", {34'h0, out_valid}, 35'h0);
  endtask

  task automatic t_normalize();
    expect_word("R2 aligned", 1'b0, 0, 28'h4000000, 2'b00, {32'h40800000, 3'b000});
    expect_word("R2 sign", 1'b1, 5, 28'h4000008, 2'b00, {32'hC5800001, 3'b000});
    expect_word("R3 left shift 6", 1'b0, 0, 28'h0100000, 2'b00, {32'h3A800000, 3'b000});
    expect_word("R4 right shift chop", 1'b0, 0, 28'h8000001, 2'b00, {32'h41800000, 3'b000});
    expect_word("R4 right shift jam", 1'b0, 0, 28'h8000001, 2'b01, {32'h41800001, 3'b000});
  endtask

  task automatic t_modes();
    expect_word("R5 chop", 1'b0, 0, 28'h4000007, 2'b00, {32'h40800000, 3'b000});
    expect_word("R6 jam", 1'b0, 0, 28'h4000003, 2'b01, {32'h40800001, 3'b000});
    expect_word("R6 jam no guard", 1'b0, 0, 28'h4000010, 2'b01, {32'h40800002, 3'b000});
    expect_word("R7 round below half", 1'b0, 0, 28'h4000003, 2'b10, {32'h40800000, 3'b000});
    expect_word("R7 round up", 1'b0, 0, 28'h4000004, 2'b10, {32'h40800001, 3'b000});
    expect_word("R8 mode 11", 1'b0, 0, 28'h4000007, 2'b11, {32'h40800000, 3'b000});
  endtask

  task automatic t_round_carry();
    expect_word("R9 carry renorm", 1'b0, 0, 28'h7FFFFFC, 2'b10, {32'h41800000, 3'b000});
    expect_word("R9 chop keeps", 1'b0, 0, 28'h7FFFFFC, 2'b00, {32'h40FFFFFF, 3'b000});
    expect_word("R11 carry overflow", 1'b0, 63, 28'h7FFFFFC, 2'b10, {32'h7FFFFFFF, 3'b100});
  endtask

  task automatic t_zero();
    expect_word("R10 zero", 1'b1, 17, 28'h0, 2'b10, {32'h0, 3'b001});
  endtask

  task automatic t_range();
    expect_word("R11 overflow", 1'b1, 63, 28'h8000000, 2'b00, {32'hFFFFFFFF, 3'b100});
    expect_word("R11 max in range", 1'b0, 63, 28'h4000000, 2'b00, {32'h7F800000, 3'b000});
    expect_word("R12 underflow", 1'b1, -62, 28'h0800000, 2'b00, {32'h80000000, 3'b010});
    expect_word("R12 min in range", 1'b0, -64, 28'h4000000, 2'b00, {32'h00800000, 3'b000});
  endtask

  task automatic t_hold();
    logic [34:0] res;
    run(1'b0, 3, 28'h6000000, 2'b00, res);
    @(negedge clk);
    sign_in = 1'b1; mant_in = 28'h0000001; exp_in = -10'sd40;
    @(negedge clk);
    check("R1 hold", {word, ovf, unf, zero}, {32'h43C00000, 3'b000});
    check("R1 valid drop", {34'h0, out_valid}, 35'h0);
  endtask

  task automatic t_sweep();
    logic [34:0] res;
    logic [27:0] m;
    int e;
    for (int i = 0; i < 300; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      m = rng[27:0] >> (rng[31:27] % 28);
      e = int'(rng[13:6] % 8'd170) - 85;
      run(rng[30], e, m, rng[2:1], res);
      check("R2 R3 R4 R7 sweep", res, model(rng[30], e, m, rng[2:1]));
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_normalize();
    t_modes();
    t_round_carry();
    t_zero();
    t_range();
    t_hold();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule